// File: doc/BRIEF.md
# Flash Status Register Unit

This block holds the 8-bit status byte of a multi-bank NOR-style flash controller. An internal program/erase engine reports its activity as single-cycle pulses: an operation starts or ends, an erase or program is suspended or resumed, a failure is detected, or the buffered factory-program flag moves. The unit folds these pulses into live status. Status bits follow the engine by themselves. Error bits stay set until a Clear Status strobe or a hardware reset.

The read path gets a captured copy of the byte. The bus strobes chip-enable and output-enable arrive asynchronously and each passes through a two-flop synchronizer. A falling edge on either one loads the live byte into the output register. The captured copy then stays frozen until the strobe that loaded it goes high again. The strobe protocol already fixes when the byte is valid, so the read byte has no valid/ready handshake and no back-pressure; every pin is a plain control or status pin.

The unit also drives two flags for the command logic. An error-pending flag lets it refuse new program or erase commands until status is cleared. A redirect flag tells it to answer reads of the busy bank with status instead of array data.

Top module: `fsr_unit`

## Requirements
- R1: Bit 7 is 0 from the cycle after an `op_start_i` pulse and returns to 1 after an `op_done_i` pulse. When both pulse in the same cycle, start wins and bit 7 is 0.
- R2: Bit 6 is set by `esus_set_i` and cleared by `esus_clr_i`. Bit 2 is set by `psus_set_i` and cleared by `psus_clr_i`.
- R3: Error bits are sticky and are set by pulses on `err_i`: `err_i[3]` sets bit 5 (erase/blank-check failure), `err_i[2]` sets bit 4 (program failure), `err_i[1]` sets bit 3 (bad programming voltage) and `err_i[0]` sets the protection error. Only `clr_i` or reset clears them. A set and `clr_i` in the same cycle leave the bit set.
- R4: While bit 7 is 0, bit 1 is 1 when `addr_bank_i` differs from the bank captured with `op_start_i`, and 0 when the two match. While bit 7 is 1, bit 1 shows the latched protection error.
- R5: Bit 0 is set by `buf_set_i` and cleared by `buf_clr_i`.
- R6: A falling edge of synchronized chip-enable or output-enable loads the live status into `stat_o`. The value in `stat_o` changes only on such a load. After a load, further falling edges are ignored until the strobe that made the load has been high again.
- R7: `err_pend_o` is 1 exactly when any latched error bit is set, including a protection error that bit 1 is not showing.
- R8: `redirect_o` is 1 while an operation is running in the addressed bank and no `rd_array_i` pulse has come since that operation started.
- R9: While reset is asserted, live status and `stat_o` both read 0x80 and `err_pend_o` and `redirect_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| op_start_i | input | 1 | Pulse: a program/erase begins |
| op_done_i | input | 1 | Pulse: a program/erase ends |
| op_bank_i | input | BANK_W | Bank of the operation, taken at op_start_i |
| addr_bank_i | input | BANK_W | Bank currently addressed by the bus |
| esus_set_i | input | 1 | Pulse: erase suspended |
| esus_clr_i | input | 1 | Pulse: erase resumed |
| psus_set_i | input | 1 | Pulse: program suspended |
| psus_clr_i | input | 1 | Pulse: program resumed |
| err_i | input | 4 | Error pulses {erase, program, voltage, protection} |
| clr_i | input | 1 | Clear Status strobe |
| buf_set_i | input | 1 | Pulse: buffer-mode flag set |
| buf_clr_i | input | 1 | Pulse: buffer-mode flag cleared |
| rd_array_i | input | 1 | Pulse: Read Array command seen |
| ce_n_i | input | 1 | Asynchronous chip-enable, active low |
| oe_n_i | input | 1 | Asynchronous output-enable, active low |
| stat_o | output | 8 | Captured status byte for the read path |
| err_pend_o | output | 1 | Some error bit is latched |
| redirect_o | output | 1 | Reads of the busy bank return status |

## Verification
The hardest case to reach is a load made by one strobe while the other strobe toggles. The bench drops output-enable to make a load and then changes the engine state. It then drops chip-enable and raises output-enable while chip-enable stays low. The output has to keep the first byte through all of this, and a fresh load must wait for a new falling edge. A second case is a protection error latched during a busy operation: bit 1 shows bank activity at that time, so the bench checks that the error still drives the pending flag and appears in bit 1 once the operation ends.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SR_W   = 8;
  localparam int ERR_W  = 4;
  localparam int B_RDY  = 7;
  localparam int B_ESUS = 6;
  localparam int B_EERR = 5;
  localparam int B_PERR = 4;
  localparam int B_VERR = 3;
  localparam int B_PSUS = 2;
  localparam int B_BANK = 1;
  localparam int B_BUF  = 0;
  localparam logic [SR_W-1:0] SR_RESET = 8'h80;
endpackage

// File: rtl/fsr_strobe_sync.sv
module fsr_strobe_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_n_i,
  output logic [W-1:0] lvl_n_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_ch
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= async_n_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_n_o[g] = s2_q;
    assign fall_o[g]  = s3_q & ~s2_q;
  end
endmodule

// File: rtl/fsr_state.sv
module fsr_state
  import fsr_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start_i,
  input  logic              op_done_i,
  input  logic [BANK_W-1:0] op_bank_i,
  input  logic [BANK_W-1:0] addr_bank_i,
  input  logic              esus_set_i,
  input  logic              esus_clr_i,
  input  logic              psus_set_i,
  input  logic              psus_clr_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              clr_i,
  input  logic              buf_set_i,
  input  logic              buf_clr_i,
  input  logic              rd_array_i,
  output logic [SR_W-1:0]   live_o,
  output logic              err_pend_o,
  output logic              redirect_o
);
  logic              busy_q, esus_q, psus_q, buf_q, ra_seen_q;
  logic [BANK_W-1:0] bank_q;
  logic [ERR_W-1:0]  err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      bank_q    <= '0;
      ra_seen_q <= 1'b0;
    end else begin
      if (op_start_i) begin
        busy_q    <= 1'b1;
        bank_q    <= op_bank_i;
        ra_seen_q <= 1'b0;
      end else begin
        if (op_done_i)  busy_q    <= 1'b0;
        if (rd_array_i) ra_seen_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esus_q <= 1'b0;
      psus_q <= 1'b0;
      buf_q  <= 1'b0;
    end else begin
      if (esus_set_i)      esus_q <= 1'b1;
      else if (esus_clr_i) esus_q <= 1'b0;
      if (psus_set_i)      psus_q <= 1'b1;
      else if (psus_clr_i) psus_q <= 1'b0;
      if (buf_set_i)       buf_q  <= 1'b1;
      else if (buf_clr_i)  buf_q  <= 1'b0;
    end
  end

  // sticky errors: a new failure beats a clear arriving in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= '0;
    else if (clr_i) err_q <= err_i;
    else            err_q <= err_q | err_i;
  end

  always_comb begin
    live_o         = '0;
    live_o[B_RDY]  = ~busy_q;
    live_o[B_ESUS] = esus_q;
    live_o[B_EERR] = err_q[3];
    live_o[B_PERR] = err_q[2];
    live_o[B_VERR] = err_q[1];
    live_o[B_PSUS] = psus_q;
    live_o[B_BANK] = busy_q ? (bank_q != addr_bank_i) : err_q[0];
    live_o[B_BUF]  = buf_q;
  end

  assign err_pend_o = |err_q;
  assign redirect_o = busy_q & ~ra_seen_q & (bank_q == addr_bank_i);

  // R3: without a clear, no latched error bit drops
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R1: a start pulse makes the ready bit low next cycle
  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_i |=> !live_o[B_RDY]);
  // R7: pending flag only rises after an error pulse
  p_errpend_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pend_o) |-> $past(|err_i));
  // R8: redirect only while busy
  p_redirect_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> !live_o[B_RDY]);
endmodule

// File: rtl/fsr_unit.sv
module fsr_unit
  import fsr_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start_i,
  input  logic              op_done_i,
  input  logic [BANK_W-1:0] op_bank_i,
  input  logic [BANK_W-1:0] addr_bank_i,
  input  logic              esus_set_i,
  input  logic              esus_clr_i,
  input  logic              psus_set_i,
  input  logic              psus_clr_i,
  input  logic [3:0]        err_i,
  input  logic              clr_i,
  input  logic              buf_set_i,
  input  logic              buf_clr_i,
  input  logic              rd_array_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  output logic [7:0]        stat_o,
  output logic              err_pend_o,
  output logic              redirect_o
);
  localparam int NSTB = 2;  // index 0 = chip-enable, 1 = output-enable

  logic [SR_W-1:0] live;
  logic [NSTB-1:0] lvl_n, fall;
  logic            hold_q, src_q;
  logic [SR_W-1:0] stat_q;

  fsr_state #(.BANK_W(BANK_W)) state_i (
    .clk(clk), .rst_n(rst_n),
    .op_start_i(op_start_i), .op_done_i(op_done_i),
    .op_bank_i(op_bank_i), .addr_bank_i(addr_bank_i),
    .esus_set_i(esus_set_i), .esus_clr_i(esus_clr_i),
    .psus_set_i(psus_set_i), .psus_clr_i(psus_clr_i),
    .err_i(err_i), .clr_i(clr_i),
    .buf_set_i(buf_set_i), .buf_clr_i(buf_clr_i),
    .rd_array_i(rd_array_i),
    .live_o(live), .err_pend_o(err_pend_o), .redirect_o(redirect_o)
  );

  fsr_strobe_sync #(.W(NSTB)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .async_n_i({oe_n_i, ce_n_i}),
    .lvl_n_o(lvl_n), .fall_o(fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      src_q  <= 1'b0;
      stat_q <= SR_RESET;
    end else if (hold_q) begin
      if (lvl_n[src_q]) hold_q <= 1'b0;
    end else if (|fall) begin
      hold_q <= 1'b1;
      src_q  <= ~fall[0];
      stat_q <= live;
    end
  end

  assign stat_o = stat_q;

  // R6: while the capturing strobe stays low the byte is frozen
  p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !lvl_n[src_q]) |=> $stable(stat_o));
  // R6: byte only moves on a synchronized falling edge
  p_load_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_o) |-> $past(|fall));
endmodule

// File: tb/fsr_unit_tb_top.sv
module fsr_unit_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic op_start = 0, op_done = 0, esus_set = 0, esus_clr = 0;
  logic psus_set = 0, psus_clr = 0, clr = 0, buf_set = 0, buf_clr = 0;
  logic rd_array = 0, ce_n = 1, oe_n = 1;
  logic [1:0] op_bank = 0, addr_bank = 0;
  logic [3:0] err = 0;
  logic [7:0] stat;
  logic err_pend, redirect;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  event smp;

  fsr_unit #(.BANK_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .op_start_i(op_start), .op_done_i(op_done),
    .op_bank_i(op_bank), .addr_bank_i(addr_bank),
    .esus_set_i(esus_set), .esus_clr_i(esus_clr),
    .psus_set_i(psus_set), .psus_clr_i(psus_clr),
    .err_i(err), .clr_i(clr), .buf_set_i(buf_set), .buf_clr_i(buf_clr),
    .rd_array_i(rd_array), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .stat_o(stat), .err_pend_o(err_pend), .redirect_o(redirect)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected byte when the driver signals a sample point
  always @(smp) begin
    logic [7:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(stat, e, t);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one chip-enable read cycle, expectation pushed to the scoreboard
  task automatic rd(input logic [7:0] exp, input string tag, input logic use_oe = 0);
    @(negedge clk);
    if (use_oe) oe_n = 0; else ce_n = 0;
    step(4);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> smp;
    @(negedge clk);
    if (use_oe) oe_n = 1; else ce_n = 1;
    step(4);
  endtask

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(2);
    chk(stat, 8'h80, "R9 reset byte");
    chk({6'b0, err_pend, redirect}, 8'h00, "R9 reset flags");
    rst_n = 1;
    step(2);
    rd(8'h80, "R9 ready after reset");

    op_bank = 1; addr_bank = 1;
    @(negedge clk) op_start = 1; @(negedge clk) op_start = 0;
    rd(8'h00, "R1 R4 busy same bank");
    chk({7'b0, redirect}, 8'h01, "R8 redirect armed");
    addr_bank = 2;
    rd(8'h02, "R4 busy other bank");
    chk({7'b0, redirect}, 8'h00, "R8 other bank no redirect");
    addr_bank = 1;
    @(negedge clk) rd_array = 1; @(negedge clk) rd_array = 0;
    chk({7'b0, redirect}, 8'h00, "R8 read array cancels");

    @(negedge clk) esus_set = 1; @(negedge clk) esus_set = 0;
    rd(8'h40, "R2 erase suspend");
    @(negedge clk) psus_set = 1; @(negedge clk) psus_set = 0;
    rd(8'h44, "R2 both suspends");
    @(negedge clk) begin esus_clr = 1; psus_clr = 1; end
    @(negedge clk) begin esus_clr = 0; psus_clr = 0; end
    rd(8'h00, "R2 resumed");
    @(negedge clk) buf_set = 1; @(negedge clk) buf_set = 0;
    rd(8'h01, "R5 buffer flag set");
    @(negedge clk) buf_clr = 1; @(negedge clk) buf_clr = 0;
    rd(8'h00, "R5 buffer flag clear");
    @(negedge clk) op_done = 1; @(negedge clk) op_done = 0;
    rd(8'h80, "R1 ready after done");

    @(negedge clk) err = 4'b0001; @(negedge clk) err = 0;
    rd(8'h82, "R3 R4 protection error");
    chk({7'b0, err_pend}, 8'h01, "R7 pending on error");
    @(negedge clk) err = 4'b0010; @(negedge clk) err = 0;
    rd(8'h8A, "R3 voltage error sticky");
    @(negedge clk) err = 4'b1100; @(negedge clk) err = 0;
    rd(8'hBA, "R3 erase program errors");
    @(negedge clk) clr = 1; @(negedge clk) clr = 0;
    rd(8'h80, "R3 clear");
    chk({7'b0, err_pend}, 8'h00, "R7 pending cleared");
    @(negedge clk) begin clr = 1; err = 4'b0100; end
    @(negedge clk) begin clr = 0; err = 0; end
    rd(8'h90, "R3 set beats clear");
    @(negedge clk) clr = 1; @(negedge clk) clr = 0;

    @(negedge clk) begin op_start = 1; op_done = 1; end
    @(negedge clk) begin op_start = 0; op_done = 0; end
    rd(8'h00, "R1 start wins");
    @(negedge clk) op_done = 1; @(negedge clk) op_done = 0;

    // R6 freeze under chip-enable
    @(negedge clk) ce_n = 0;
    step(4);
    @(negedge clk) op_start = 1; @(negedge clk) op_start = 0;
    step(4);
    chk(stat, 8'h80, "R6 frozen while ce low");
    @(negedge clk) ce_n = 1;
    step(4);
    chk(stat, 8'h80, "R6 no change on release");
    rd(8'h00, "R6 new load");
    @(negedge clk) op_done = 1; @(negedge clk) op_done = 0;

    // R6 output-enable loads, chip-enable edges ignored
    @(negedge clk) oe_n = 0;
    step(4);
    @(negedge clk) op_start = 1; @(negedge clk) op_start = 0;
    @(negedge clk) ce_n = 0;
    step(4);
    chk(stat, 8'h80, "R6 ce edge ignored while held");
    @(negedge clk) oe_n = 1;
    step(5);
    chk(stat, 8'h80, "R6 no load without new edge");
    @(negedge clk) ce_n = 1;
    step(4);
    rd(8'h00, "R6 oe load", 1'b1);

    // protection error while busy
    @(negedge clk) err = 4'b0001; @(negedge clk) err = 0;
    rd(8'h00, "R4 bank view hides protection");
    chk({7'b0, err_pend}, 8'h01, "R7 hidden error pending");
    @(negedge clk) op_done = 1; @(negedge clk) op_done = 0;
    rd(8'h82, "R4 protection shown when ready");
    @(negedge clk) clr = 1; @(negedge clk) clr = 0;
    @(negedge clk) op_start = 1; @(negedge clk) op_start = 0;
    step(1);
    chk({7'b0, redirect}, 8'h01, "R8 rearmed by new start");

    step(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule